// File: doc/BRIEF.md
# Condition Code Register and Branch Evaluator

This block keeps the 8-bit processor status byte of a small 8/16-bit CPU core and decides whether a conditional branch is taken. The execute stage feeds it per-flag update enables and values from the ALU. The control path feeds it whole-byte operations: load, AND with a mask, OR with a mask, or XOR with a mask. The interrupt controller pulses a strobe on interrupt entry, and that strobe sets the mask bit.

The byte has a fixed layout. The most significant bit is the interrupt mask. Two software-only user bits sit at positions 6 and 4, and the half-carry flag sits between them at position 5. The low nibble holds negative, zero, overflow and carry. Reading the status out is done from the `ccr_q` output.

A 4-bit selector picks one of sixteen branch tests, and `branch_taken` reports the result. The tests cover always and never, single-flag tests, unsigned magnitude compares and signed magnitude compares.

Top module: `cc_flag_branch`

## Requirements
- R1: After reset `ccr_q` is 8'h80: the mask bit I (bit 7) is 1 and every other bit is 0.
- R2: When `ctl_op` is idle, each `flag_we` bit that is set loads its `flag_val` bit into the register at the next clock edge. Bit mapping: index 4 is H (bit 5), 3 is N (bit 3), 2 is Z (bit 2), 1 is V (bit 1) and 0 is C (bit 0). Flags whose enable is clear keep their value.
- R3: ALU flag updates never change I (bit 7) or the user bits 6 and 4.
- R4: `ctl_op` selects a whole-byte operation with `ctl_data`, applied at the next edge. The codes are: 1 load, 2 AND, 3 OR, 4 XOR. Codes 0, 5, 6 and 7 are idle and leave the register unchanged unless a flag update or interrupt entry is present.
- R5: When a control operation and ALU flag updates occur in the same cycle, the control operation alone decides the new byte.
- R6: `irq_entry` sets I to 1 at the next edge. It wins over a control operation that clears I in the same cycle, while the other seven bits still follow that control operation.
- R7: `branch_taken` is evaluated combinationally from the current `ccr_q` and `cond_sel` (default variant). Code 0 is always taken and code 1 is never taken.
- R8: Unsigned tests: code 2 is taken when (C|Z)=0, code 3 when (C|Z)=1, code 4 when C=0 and code 5 when C=1.
- R9: Single-flag tests: code 6 is taken when Z=0, 7 when Z=1, 8 when V=0, 9 when V=1, 10 when N=0 and 11 when N=1.
- R10: Signed tests: code 12 is taken when N^V=0, 13 when N^V=1, 14 when Z|(N^V)=0 and 15 when Z|(N^V)=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 5 | Per-flag ALU update enables {H,N,Z,V,C} |
| flag_val | input | 5 | Per-flag ALU values {H,N,Z,V,C} |
| ctl_op | input | 3 | Whole-byte operation code |
| ctl_data | input | 8 | Immediate or register operand for the control operation |
| irq_entry | input | 1 | Interrupt entry strobe |
| cond_sel | input | 4 | Branch test selector |
| ccr_q | output | 8 | Current status byte |
| branch_taken | output | 1 | Result of the selected branch test |

## Verification
Every update to the status byte, whether from a flag, a control operation or interrupt entry, becomes visible on `ccr_q` one rising edge after the cycle in which the stimulus is presented. The bench therefore drives stimulus after a falling edge, releases it just after the following rising edge, and compares `ccr_q` at the next falling edge.

With the default combinational variant, `branch_taken` depends only on `ccr_q` and `cond_sel` in the same cycle. It is sampled a short delay after `cond_sel` changes, with no clock edge in between. The branch tests are swept over all sixteen codes for a set of status bytes that cover every combination of N, Z, V and C that matters.

// File: rtl/cc_pkg.sv
package cc_pkg;
   localparam int CC_W   = 8;
   localparam int NFLAG  = 5;
   localparam int SEL_W  = 4;
   localparam int OP_W   = 3;

   localparam int POS_I  = 7;
   localparam int POS_U1 = 6;
   localparam int POS_H  = 5;
   localparam int POS_U0 = 4;
   localparam int POS_N  = 3;
   localparam int POS_Z  = 2;
   localparam int POS_V  = 1;
   localparam int POS_C  = 0;

   localparam logic [CC_W-1:0] CC_RESET = 8'h80;

   typedef enum logic [OP_W-1:0] {
      OP_IDLE = 3'd0,
      OP_LOAD = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4
   } cc_op_e;

   typedef enum logic [SEL_W-1:0] {
      T_ALWAYS = 4'd0,  T_NEVER = 4'd1,
      T_HI     = 4'd2,  T_LS    = 4'd3,
      T_CCLR   = 4'd4,  T_CSET  = 4'd5,
      T_ZCLR   = 4'd6,  T_ZSET  = 4'd7,
      T_VCLR   = 4'd8,  T_VSET  = 4'd9,
      T_NCLR   = 4'd10, T_NSET  = 4'd11,
      T_GE     = 4'd12, T_LT    = 4'd13,
      T_GT     = 4'd14, T_LE    = 4'd15
   } cc_test_e;

   // Map an ALU flag index to its bit position in the status byte.
   function automatic int flag_pos(input int k);
      return (k == NFLAG-1) ? POS_H : k;
   endfunction
endpackage

// File: rtl/cc_status_reg.sv
module cc_status_reg
   import cc_pkg::*;
#(
   parameter logic [CC_W-1:0] RST_VAL = CC_RESET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] flag_we,
   input  logic [NFLAG-1:0] flag_val,
   input  logic [OP_W-1:0]  ctl_op,
   input  logic [CC_W-1:0]  ctl_data,
   input  logic             irq_entry,
   output logic [CC_W-1:0]  ccr_q
);
   if (!RST_VAL[POS_I]) begin : g_rst_chk
      $error("cc_status_reg: reset value must leave interrupts masked");
   end

   logic [CC_W-1:0] alu_mask;
   logic [CC_W-1:0] alu_bits;
   logic [CC_W-1:0] ccr_d;

   assign alu_mask[POS_I]  = 1'b0;
   assign alu_mask[POS_U1] = 1'b0;
   assign alu_mask[POS_U0] = 1'b0;
   assign alu_bits[POS_I]  = 1'b0;
   assign alu_bits[POS_U1] = 1'b0;
   assign alu_bits[POS_U0] = 1'b0;

   for (genvar k = 0; k < NFLAG; k++) begin : g_map
      localparam int P = flag_pos(k);
      assign alu_mask[P] = flag_we[k];
      assign alu_bits[P] = flag_val[k];
   end

   always_comb begin
      case (cc_op_e'(ctl_op))
         OP_LOAD: ccr_d = ctl_data;
         OP_AND:  ccr_d = ccr_q & ctl_data;
         OP_OR:   ccr_d = ccr_q | ctl_data;
         OP_XOR:  ccr_d = ccr_q ^ ctl_data;
         default: ccr_d = (ccr_q & ~alu_mask) | (alu_bits & alu_mask);
      endcase
      if (irq_entry) ccr_d[POS_I] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ccr_q <= RST_VAL;
      else        ccr_q <= ccr_d;
   end

   logic ctl_active;
   assign ctl_active = (ctl_op == OP_LOAD) || (ctl_op == OP_AND) ||
                       (ctl_op == OP_OR)   || (ctl_op == OP_XOR);

   // R6
   irq_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_entry |=> ccr_q[POS_I]);

   // R3
   user_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_active |=> ($stable(ccr_q[POS_U1]) && $stable(ccr_q[POS_U0])));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_active && !irq_entry && flag_we == '0) |=> $stable(ccr_q));

   // R4
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_op == OP_LOAD && !irq_entry) |=> (ccr_q == $past(ctl_data)));
endmodule

// File: rtl/cc_test_eval.sv
module cc_test_eval
   import cc_pkg::*;
#(
   parameter int TAKEN_REG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CC_W-1:0]  ccr,
   input  logic [SEL_W-1:0] sel,
   output logic             taken
);
   if (TAKEN_REG != 0 && TAKEN_REG != 1) begin : g_par_chk
      $error("cc_test_eval: TAKEN_REG must be 0 or 1");
   end

   logic f_n, f_z, f_v, f_c, lt_s, le_u;
   logic raw;

   assign f_n  = ccr[POS_N];
   assign f_z  = ccr[POS_Z];
   assign f_v  = ccr[POS_V];
   assign f_c  = ccr[POS_C];
   assign lt_s = f_n ^ f_v;
   assign le_u = f_c | f_z;

   // Each pair of codes is a test and its complement: bit 0 inverts.
   always_comb begin
      logic base;
      case (sel[SEL_W-1:1])
         3'd0: base = 1'b1;
         3'd1: base = ~le_u;
         3'd2: base = ~f_c;
         3'd3: base = ~f_z;
         3'd4: base = ~f_v;
         3'd5: base = ~f_n;
         3'd6: base = ~lt_s;
         default: base = ~(f_z | lt_s);
      endcase
      raw = base ^ sel[0];
   end

   if (TAKEN_REG == 0) begin : g_comb
      assign taken = raw;

      // R7
      always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == T_ALWAYS) |-> taken);

      // R7
      never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == T_NEVER) |-> !taken);

      // R10
      gt_excludes_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == T_GT && ccr[POS_Z]) |-> !taken);
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) taken <= 1'b0;
         else        taken <= raw;
      end

      // R7
      always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == T_ALWAYS) |=> taken);
   end
endmodule

// File: rtl/cc_flag_branch.sv
module cc_flag_branch
   import cc_pkg::*;
#(
   parameter int TAKEN_REG = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [4:0] flag_we,
   input  logic [4:0] flag_val,
   input  logic [2:0] ctl_op,
   input  logic [7:0] ctl_data,
   input  logic       irq_entry,
   input  logic [3:0] cond_sel,
   output logic [7:0] ccr_q,
   output logic       branch_taken
);
   cc_status_reg #(.RST_VAL(CC_RESET)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .flag_we   (flag_we),
      .flag_val  (flag_val),
      .ctl_op    (ctl_op),
      .ctl_data  (ctl_data),
      .irq_entry (irq_entry),
      .ccr_q     (ccr_q)
   );

   cc_test_eval #(.TAKEN_REG(TAKEN_REG)) u_eval (
      .clk   (clk),
      .rst_n (rst_n),
      .ccr   (ccr_q),
      .sel   (cond_sel),
      .taken (branch_taken)
   );
endmodule

// File: tb/sim_cc_flag_branch.sv
module sim_cc_flag_branch;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] flag_we = '0;
   logic [4:0] flag_val = '0;
   logic [2:0] ctl_op = '0;
   logic [7:0] ctl_data = '0;
   logic       irq_entry = 1'b0;
   logic [3:0] cond_sel = '0;
   logic [7:0] ccr_q;
   logic       branch_taken;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   cc_flag_branch u0 (
      .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_val(flag_val),
      .ctl_op(ctl_op), .ctl_data(ctl_data), .irq_entry(irq_entry),
      .cond_sel(cond_sel), .ccr_q(ccr_q), .branch_taken(branch_taken)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // Present one cycle of stimulus, then sample after the update edge.
   task automatic step(input logic [4:0] we, input logic [4:0] val,
                       input logic [2:0] op, input logic [7:0] d, input logic irq);
      @(negedge clk);
      flag_we = we; flag_val = val; ctl_op = op; ctl_data = d; irq_entry = irq;
      @(posedge clk);
      #1;
      flag_we = '0; flag_val = '0; ctl_op = '0; ctl_data = '0; irq_entry = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic ref_taken(input logic [7:0] c, input logic [3:0] s);
      logic n, z, v, cy;
      n = c[3]; z = c[2]; v = c[1]; cy = c[0];
      case (s)
         4'd0:  return 1'b1;
         4'd1:  return 1'b0;
         4'd2:  return (cy | z) == 1'b0;
         4'd3:  return (cy | z) == 1'b1;
         4'd4:  return !cy;
         4'd5:  return cy;
         4'd6:  return !z;
         4'd7:  return z;
         4'd8:  return !v;
         4'd9:  return v;
         4'd10: return !n;
         4'd11: return n;
         4'd12: return (n ^ v) == 1'b0;
         4'd13: return (n ^ v) == 1'b1;
         4'd14: return (z | (n ^ v)) == 1'b0;
         default: return (z | (n ^ v)) == 1'b1;
      endcase
   endfunction

   task automatic t_reset;
      @(negedge clk);
      chk("R1 reset value", ccr_q, 8'h80);
   endtask

   task automatic t_alu_flags;
      step(5'b11111, 5'b10101, 3'd0, 8'h00, 1'b0);
      chk("R2 all flags written", ccr_q, 8'hA5);
      step(5'b00001, 5'b00000, 3'd0, 8'h00, 1'b0);
      chk("R2 only C cleared", ccr_q, 8'hA4);
      step(5'b10000, 5'b00000, 3'd0, 8'h00, 1'b0);
      chk("R2 only H cleared", ccr_q, 8'h84);
   endtask

   task automatic t_user_bits;
      step(5'b00000, 5'b00000, 3'd1, 8'h50, 1'b0);
      chk("R4 load user bits", ccr_q, 8'h50);
      step(5'b11111, 5'b00000, 3'd0, 8'h00, 1'b0);
      chk("R3 clearing flags keeps user bits", ccr_q, 8'h50);
      step(5'b11111, 5'b11111, 3'd0, 8'h00, 1'b0);
      chk("R3 setting flags keeps I and user bits", ccr_q, 8'h7F);
   endtask

   task automatic t_ctl_ops;
      step(5'b00000, 5'b00000, 3'd1, 8'h3C, 1'b0);
      chk("R4 load", ccr_q, 8'h3C);
      step(5'b00000, 5'b00000, 3'd2, 8'hF0, 1'b0);
      chk("R4 and", ccr_q, 8'h30);
      step(5'b00000, 5'b00000, 3'd3, 8'h05, 1'b0);
      chk("R4 or", ccr_q, 8'h35);
      step(5'b00000, 5'b00000, 3'd4, 8'hFF, 1'b0);
      chk("R4 xor", ccr_q, 8'hCA);
      step(5'b00000, 5'b00000, 3'd5, 8'h00, 1'b0);
      chk("R4 unused code idle", ccr_q, 8'hCA);
      step(5'b00000, 5'b00000, 3'd7, 8'h11, 1'b0);
      chk("R4 unused code 7 idle", ccr_q, 8'hCA);
   endtask

   task automatic t_priority;
      step(5'b11111, 5'b11111, 3'd1, 8'h00, 1'b0);
      chk("R5 control beats flags", ccr_q, 8'h00);
      step(5'b11111, 5'b00000, 3'd3, 8'h0F, 1'b0);
      chk("R5 or beats flag clear", ccr_q, 8'h0F);
   endtask

   task automatic t_irq;
      step(5'b00000, 5'b00000, 3'd1, 8'h11, 1'b1);
      chk("R6 irq beats load clearing I", ccr_q, 8'h91);
      step(5'b00000, 5'b00000, 3'd2, 8'h7F, 1'b0);
      chk("R6 I cleared by and", ccr_q, 8'h11);
      step(5'b00000, 5'b00000, 3'd0, 8'h00, 1'b1);
      chk("R6 irq alone sets I", ccr_q, 8'h91);
   endtask

   task automatic t_branch;
      logic [7:0] pats [10] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h08,
                                8'h02, 8'h0A, 8'h0C, 8'h06, 8'h0F};
      for (int p = 0; p < 10; p++) begin
         step(5'b00000, 5'b00000, 3'd1, pats[p], 1'b0);
         for (int s = 0; s < 16; s++) begin
            string tag;
            cond_sel = 4'(s);
            #1;
            if (s < 2)       tag = "R7";
            else if (s < 6)  tag = "R8";
            else if (s < 12) tag = "R9";
            else             tag = "R10";
            chk($sformatf("%s test %0d on %02h", tag, s, pats[p]),
                {7'd0, branch_taken}, {7'd0, ref_taken(pats[p], 4'(s))});
         end
      end
      cond_sel = '0;
   endtask

   initial begin
      #1000000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_alu_flags();
      t_user_bits();
      t_ctl_ops();
      t_priority();
      t_irq();
      t_branch();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule